// File: doc/BRIEF.md
# I2C Target Receive DMA Engine

This block sits behind an I2C target front end and takes the bytes that an external controller writes to the chip. The front end reports three byte-level events: a start of a write addressed to this target, a received data byte, and a normal stop. The engine answers each start and each byte with a one-cycle ACK or NACK pulse. It stores every accepted byte through a byte-write memory request port that works with a request and a grant.

Software programs a receive buffer base address, a buffer length written as N-1, a command word that holds the receive-DMA enable, and a device address. At an accepted start the engine loads a working address counter and a working length counter from these registers, and it clears a separate received-byte count. Each stored byte advances the working counters. A stop raises four completion flags, and these drive the interrupt output.

Top module: `i2c_tgt_rx_dma`

## Requirements
- R1: When the command register bit 0 (receive enable) is 0, a start gets a NACK pulse one cycle later and no counter or status changes.
- R2: When the enable is 1, a start gets an ACK pulse. It clears the received count (offset 5), loads the working address (offset 6) from the base register (offset 1), and loads the working length (offset 7) with length field bits [LW-1:0] of offset 2, plus one.
- R3: An accepted byte is written to memory at the working address. After the grant the working address rises by one, the working length falls by one, the received count rises by one, and an ACK pulse follows.
- R4: A stop after an accepted start sets status (offset 4) bits 0 (packet done), 1 (address matched), 2 (normal stop) and 3 (receive done) together, and irq goes high.
- R5: A write to offset 2 with bit 31 set changes only bits [LW-1:0]. Without bit 31 the whole register is replaced.
- R6: A write to offset 3 with bit 31 set ORs the value into the register, and otherwise replaces it. Every write to offset 3 copies the device address (offset 0, bits [6:0]) to tgt_addr.
- R7: Any write to offset 5 clears the received count to zero.
- R8: Writes to offsets 6 and 7 have no effect.
- R9: While mem_req is high and mem_gnt is low, mem_req, mem_addr and mem_data hold steady, and the byte ACK waits for the grant.
- R10: A byte that arrives when the working length is zero gets a NACK and is not stored.
- R11: Writing 1s to status bits clears those bits. irq is high exactly when any status bit is set.
- R12: After reset all registers, counters, flags and outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ev_start | input | 1 | Start of an addressed write |
| ev_byte | input | 1 | Data byte received |
| ev_data | input | 8 | Received byte |
| ev_stop | input | 1 | Normal stop |
| ev_ack | output | 1 | ACK pulse to the bus |
| ev_nack | output | 1 | NACK pulse to the bus |
| mem_req | output | 1 | Byte write request |
| mem_addr | output | AW | Byte write address |
| mem_data | output | 8 | Byte write data |
| mem_gnt | input | 1 | Write accepted |
| tgt_addr | output | 7 | Own target address |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the engine with LW=4 and AW=16. With these values the largest buffer is only sixteen bytes, so a full buffer and the overrun NACK after it are reached in a few dozen cycles. The bit-31 partial write is also visible, because it has to keep the upper length bits. The bench's memory responder inserts grant delays of zero to several cycles, which exercises the hold-until-grant rule and shows that the ACK comes late when the grant is late.

// File: rtl/i2c_tgt_rx_dma.sv
module i2c_tgt_rx_dma #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          ev_start,
  input  logic          ev_byte,
  input  logic [7:0]    ev_data,
  input  logic          ev_stop,
  output logic          ev_ack,
  output logic          ev_nack,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_data,
  input  logic          mem_gnt,
  output logic [6:0]    tgt_addr,
  output logic          irq
);
  localparam int CW = LW + 1;

  typedef enum logic [1:0] {S_IDLE, S_ACTIVE, S_WAIT} st_t;
  st_t st;

  logic [6:0]    dev_q;
  logic [AW-1:0] base_q, waddr_q;
  logic [31:0]   len_q, cmd_q;
  logic [3:0]    stat_q;
  logic [CW-1:0] wlen_q, rxcnt_q;
  logic [7:0]    byte_q;

  wire en = cmd_q[0];

  assign mem_req  = (st == S_WAIT);
  assign mem_addr = waddr_q;
  assign mem_data = byte_q;
  assign irq      = |stat_q;

  always_comb begin
    case (reg_addr)
      3'd0: reg_rdata = {25'b0, dev_q};
      3'd1: reg_rdata = 32'(base_q);
      3'd2: reg_rdata = len_q;
      3'd3: reg_rdata = cmd_q;
      3'd4: reg_rdata = {28'b0, stat_q};
      3'd5: reg_rdata = 32'(rxcnt_q);
      3'd6: reg_rdata = 32'(waddr_q);
      default: reg_rdata = 32'(wlen_q);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      dev_q <= '0; base_q <= '0; len_q <= '0; cmd_q <= '0;
      stat_q <= '0; waddr_q <= '0; wlen_q <= '0; rxcnt_q <= '0;
      byte_q <= '0; tgt_addr <= '0; ev_ack <= 1'b0; ev_nack <= 1'b0;
    end else begin
      ev_ack  <= 1'b0;
      ev_nack <= 1'b0;
      if (reg_wr) begin
        case (reg_addr)
          3'd0: dev_q <= reg_wdata[6:0];
          3'd1: base_q <= reg_wdata[AW-1:0];
          3'd2: if (reg_wdata[31]) len_q[LW-1:0] <= reg_wdata[LW-1:0];
                else len_q <= reg_wdata;
          3'd3: begin
            cmd_q    <= reg_wdata[31] ? (cmd_q | reg_wdata) : reg_wdata;
            tgt_addr <= dev_q;
          end
          3'd4: stat_q <= stat_q & ~reg_wdata[3:0];
          3'd5: rxcnt_q <= '0;
          default: ;
        endcase
      end
      case (st)
        S_WAIT: if (mem_gnt) begin
          waddr_q <= waddr_q + 1'b1;
          wlen_q  <= wlen_q - 1'b1;
          rxcnt_q <= rxcnt_q + 1'b1;
          ev_ack  <= 1'b1;
          st      <= S_ACTIVE;
        end
        default: begin
          if (ev_start) begin
            if (!en) ev_nack <= 1'b1;
            else begin
              rxcnt_q <= '0;
              waddr_q <= base_q;
              wlen_q  <= {1'b0, len_q[LW-1:0]} + 1'b1;
              ev_ack  <= 1'b1;
              st      <= S_ACTIVE;
            end
          end else if (ev_byte) begin
            if (st == S_ACTIVE && wlen_q != '0) begin
              byte_q <= ev_data;
              st     <= S_WAIT;
            end else ev_nack <= 1'b1;
          end else if (ev_stop && st == S_ACTIVE) begin
            stat_q <= stat_q | 4'hF;
            st     <= S_IDLE;
          end
        end
      endcase
    end
  end

  AST_REFUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start && !en && st != S_WAIT) |=> (ev_nack && !ev_ack && $stable(waddr_q) && $stable(wlen_q))); // R1
  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start && en && st != S_WAIT) |=> (ev_ack && rxcnt_q == '0)); // R2
  AST_BYTE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_gnt) |=> (waddr_q == $past(waddr_q) + 1'b1 && ev_ack)); // R3
  AST_STOP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && !ev_start && !ev_byte && st == S_ACTIVE) |=> (stat_q == 4'hF && irq)); // R4
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_data) && !ev_ack)); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_byte && !ev_start && st == S_ACTIVE && wlen_q == '0) |=> (!mem_req && ev_nack)); // R10
  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_ack, ev_nack})); // R3
endmodule

// File: tb/tb_i2c_tgt_rx_dma.sv
module tb_i2c_tgt_rx_dma;
  localparam int AW = 16;
  localparam int LW = 4;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0; logic [2:0] reg_addr = 0; logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic ev_start = 0, ev_byte = 0, ev_stop = 0; logic [7:0] ev_data = 0;
  logic ev_ack, ev_nack, mem_req, mem_gnt = 0, irq;
  logic [AW-1:0] mem_addr; logic [7:0] mem_data; logic [6:0] tgt_addr;

  int errors = 0, checks = 0;
  int gnt_delay = 0, wait_cnt = 0, writes = 0, hold_bad = 0;
  logic [7:0] mem [0:255];
  logic [AW-1:0] last_addr; logic [7:0] last_data; logic last_req = 0;

  always #4 clk = ~clk;

  i2c_tgt_rx_dma #(.AW(AW), .LW(LW)) dut (.*);

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: run hung");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(negedge clk) begin
    if (mem_req && last_req && !mem_gnt && (mem_addr != last_addr || mem_data != last_data)) hold_bad++;
    last_req <= mem_req; last_addr <= mem_addr; last_data <= mem_data;
    if (mem_req && !mem_gnt) begin
      if (wait_cnt >= gnt_delay) begin
        mem_gnt <= 1; mem[mem_addr[7:0]] <= mem_data; writes++; wait_cnt <= 0;
      end else wait_cnt <= wait_cnt + 1;
    end else mem_gnt <= 0;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s: actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); reg_addr = 3'(a); #1 d = reg_rdata;
  endtask

  task automatic resp(output int r);
    r = 0;
    for (int i = 0; i < 40 && r == 0; i++) begin
      @(negedge clk);
      if (ev_ack) r = 1; else if (ev_nack) r = 2;
    end
  endtask

  task automatic do_start(output int r);
    @(negedge clk); ev_start = 1; @(negedge clk); ev_start = 0;
    #1 r = ev_ack ? 1 : ev_nack ? 2 : 0;
  endtask

  task automatic do_byte(input logic [7:0] b, output int r);
    @(negedge clk); ev_byte = 1; ev_data = b; @(negedge clk); ev_byte = 0;
    #1 if (ev_nack) r = 2; else resp(r);
  endtask

  task automatic do_stop();
    @(negedge clk); ev_stop = 1; @(negedge clk); ev_stop = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 8; a++) begin rd(a, v); check(v == 0, "R12 reg", v, 0); end
    check(!irq && !mem_req && !ev_ack && !ev_nack && tgt_addr == 0, "R12 outputs", {irq, mem_req, tgt_addr}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(2, 32'h0000_5A37); rd(2, v); check(v == 32'h0000_5A37, "R5 full write", v, 32'h5A37);
    wr(2, 32'h8000_0009); rd(2, v); check(v == 32'h0000_5A39, "R5 trigger write", v, 32'h5A39);
    wr(0, 32'h55); wr(3, 32'h0000_0002); rd(3, v);
    check(v == 2, "R6 replace", v, 2); check(tgt_addr == 7'h55, "R6 tgt_addr", tgt_addr, 7'h55);
    wr(0, 32'h21); wr(3, 32'h8000_0001); rd(3, v);
    check(v == 32'h8000_0003, "R6 OR write", v, 32'h80000003); check(tgt_addr == 7'h21, "R6 reload", tgt_addr, 7'h21);
    wr(6, 32'h1234); wr(7, 32'h7); rd(6, v); check(v == 0, "R8 waddr RO", v, 0);
    rd(7, v); check(v == 0, "R8 wlen RO", v, 0);
  endtask

  task automatic t_refuse();
    int r; logic [31:0] v;
    wr(3, 32'h0); do_start(r); check(r == 2, "R1 nack", r, 2);
    rd(6, v); check(v == 0, "R1 waddr kept", v, 0);
    rd(7, v); check(v == 0, "R1 wlen kept", v, 0);
    do_stop(); check(!irq, "R1 no flags", irq, 0);
  endtask

  task automatic t_rx(input logic [15:0] base, input int field, input int n, input int dly);
    int r; logic [31:0] v; int w0;
    gnt_delay = dly;
    wr(1, base); wr(2, 32'h8000_0000 | field); wr(3, 1);
    wr(5, 0); do_start(r); check(r == 1, "R2 ack", r, 1);
    rd(6, v); check(v == base, "R2 waddr", v, base);
    rd(7, v); check(v == field + 1, "R2 wlen", v, field + 1);
    rd(5, v); check(v == 0, "R2 count clear", v, 0);
    w0 = writes;
    for (int i = 0; i < n; i++) begin
      do_byte(8'(8'hA0 + i + dly), r); check(r == 1, "R3 byte ack", r, 1);
    end
    check(writes - w0 == n, "R3 writes", writes - w0, n);
    for (int i = 0; i < n; i++)
      check(mem[8'(base + i)] == 8'(8'hA0 + i + dly), "R3 data", mem[8'(base + i)], 8'(8'hA0 + i + dly));
    rd(6, v); check(v == base + n, "R3 waddr", v, base + n);
    rd(7, v); check(v == field + 1 - n, "R3 wlen", v, field + 1 - n);
    rd(5, v); check(v == n, "R3 count", v, n);
    check(hold_bad == 0, "R9 hold", hold_bad, 0);
    do_stop(); #1;
    rd(4, v); check(v == 4'hF, "R4 flags", v, 4'hF); check(irq, "R4 irq", irq, 1);
    wr(4, 32'h3); rd(4, v); check(v == 4'hC && irq, "R11 partial clear", v, 4'hC);
    wr(4, 32'hC); rd(4, v); check(v == 0 && !irq, "R11 clear", v, 0);
    wr(5, 32'h99); rd(5, v); check(v == 0, "R7 clear count", v, 0);
  endtask

  task automatic t_full();
    int r; logic [31:0] v; int w0;
    gnt_delay = 1;
    wr(1, 32'h40); wr(2, 32'h1); wr(3, 1);
    do_start(r); w0 = writes;
    do_byte(8'h11, r); do_byte(8'h22, r); check(r == 1, "R10 last fits", r, 1);
    do_byte(8'h33, r); check(r == 2, "R10 nack full", r, 2);
    check(writes - w0 == 2, "R10 not stored", writes - w0, 2);
    check(mem[8'h42] !== 8'h33, "R10 mem untouched", mem[8'h42], 0);
    rd(5, v); check(v == 2, "R10 count", v, 2);
    do_stop(); wr(4, 32'hF);
  endtask

  task automatic t_late_ack();
    int r; int cyc;
    gnt_delay = 5;
    wr(1, 32'h80); wr(2, 32'h3); wr(3, 1); do_start(r);
    @(negedge clk); ev_byte = 1; ev_data = 8'h5C; @(negedge clk); ev_byte = 0;
    cyc = 0; r = 0;
    for (int i = 0; i < 40 && r == 0; i++) begin
      @(negedge clk); cyc++; if (ev_ack) r = 1;
    end
    check(r == 1 && cyc >= 6, "R9 ack waits grant", cyc, 6);
    check(hold_bad == 0, "R9 stable", hold_bad, 0);
    do_stop(); wr(4, 32'hF);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 0;
    repeat (3) @(negedge clk); rst_n = 1;
    t_reset();
    t_regs();
    t_refuse();
    t_rx(16'h10, 5, 4, 0);
    t_rx(16'h20, 15, 16, 2);
    t_full();
    t_late_ack();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule